// File: doc/BRIEF.md
# Egress Rule-Matching TCAM

This block sits in the egress path of a switch and classifies every outgoing frame against a table of ternary rules. For each frame the upstream logic presents a 50-bit key built from the frame's metadata. The block compares the key against every valid rule at once. Each rule stores a value and a care mask, and a rule matches when the key agrees with the value on every bit the mask marks. The lowest-numbered matching rule wins. Its index and its 65-bit action word are returned two cycles after the key, together with a hit flag.

When no rule matches, the hit flag stays low. The action then comes from one of eight fallback entries, selected by the egress port number in the key modulo eight. Every rule has a sticky hit bit that records that the rule has won at least one lookup. Software reaches the table through a plain configuration port. It can write a whole rule (valid flag, value, mask and action) or a fallback action. It can also read a rule's sticky bit, and that read clears the bit.

The key layout is as follows:

- Bits 3:0 hold the egress port and bits 7:4 the ingress port.
- Bits 16:9 hold the classified ingress service index. Bit 8 flags that this index is non-zero.
- Bit 17 is the multicast flag (destination MAC bit 40 set) and bit 18 the broadcast flag (destination MAC all ones).
- Bits 30:19 carry the classified VID, bit 31 the DEI, bits 34:32 the PCP and bit 35 the drop precedence.
- Bits 45:36 carry the real-time protocol ID.
- Bits 49:46 carry the PDU type. Its codes 0 to 7 mean none, OAM CCM, MRP, DLR, RTE, IPv4, IPv6 and OAM non-CCM.

Only the egress port field is decoded by the block itself. All other fields are matched as opaque bits.

Top module: `egr_tcam`

## Requirements
- R1: A valid rule matches a key exactly when ((key XOR value) AND mask) is zero over all 50 key bits. Key bits whose mask bit is 0 have no effect on the match.
- R2: When several rules match, res_idx is the lowest matching index and res_act is that rule's action.
- R3: When no valid rule matches, res_hit is 0, res_idx is 0, and res_act is the fallback action whose number equals key bits 2:0 (the egress port, key bits 3:0, modulo 8).
- R4: res_vld is 1 exactly in the cycle two clock cycles after a cycle with key_vld at 1, and 0 otherwise. Lookups may be issued in consecutive cycles and return in order.
- R5: A rule write (cfg_rule_we at a clock edge) takes effect for every lookup whose key is presented in a later cycle. A rule written with cfg_valid at 0 never matches, whatever its mask.
- R6: A rule's sticky bit becomes 1 when the rule wins a lookup. When cfg_rd_sticky is 1 at a clock edge, cfg_sticky shows the addressed bit from the next cycle on, and the bit is cleared.
- R7: If a sticky read and a win of the same rule fall on the same clock edge, the read returns the bit's earlier value and the bit is left at 1.
- R8: After reset res_vld and res_hit are 0. All rules are invalid, all sticky bits are 0, and all fallback actions are 0.
- R9: cfg_dflt_we at a clock edge writes cfg_action into the fallback entry numbered cfg_addr bits 2:0. Later misses use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_vld | input | 1 | A lookup key is presented this cycle |
| key | input | 50 | Lookup key (layout above) |
| res_vld | output | 1 | Result of a lookup is valid this cycle |
| res_hit | output | 1 | A rule matched |
| res_idx | output | 8 | Index of the winning rule, 0 on a miss |
| res_act | output | 65 | Action of the winning rule or fallback action |
| cfg_rule_we | input | 1 | Write the whole rule at cfg_addr |
| cfg_dflt_we | input | 1 | Write fallback action cfg_addr[2:0] |
| cfg_rd_sticky | input | 1 | Read and clear the sticky bit of rule cfg_addr |
| cfg_addr | input | 8 | Rule or fallback entry number |
| cfg_valid | input | 1 | Valid flag for the rule being written |
| cfg_value | input | 50 | Compare value for the rule being written |
| cfg_mask | input | 50 | Care mask for the rule being written (1 = compare) |
| cfg_action | input | 65 | Action word for a rule or fallback write |
| cfg_sticky | output | 1 | Sticky bit returned by the last read |

## Verification
A lookup win and a software sticky read can both update the same rule's sticky bit in the same cycle. The bench provokes this by clearing the bit of a wildcard rule. It then issues a lookup that this rule wins and times the read request for the cycle in which the match sits in the first pipeline stage. The read must return 0 on that edge, and a second read must return 1, which shows that the set took priority over the clear.

// File: rtl/egr_tcam_pkg.sv
package egr_tcam_pkg;

  localparam int TCAM_KEY_W     = 50;
  localparam int TCAM_ACT_W     = 65;
  localparam int TCAM_RULES     = 256;
  localparam int TCAM_DEFAULTS  = 8;

  // egress port field position inside the key; the fallback choice decodes it
  localparam int KEY_EPORT_LSB  = 0;
  localparam int KEY_EPORT_W    = 4;

  // PDU type codes carried in key bits 49:46
  typedef enum logic [3:0] {
    PDU_NONE    = 4'd0,
    PDU_OAM_CCM = 4'd1,
    PDU_MRP     = 4'd2,
    PDU_DLR     = 4'd3,
    PDU_RTE     = 4'd4,
    PDU_IPV4    = 4'd5,
    PDU_IPV6    = 4'd6,
    PDU_OAM_OTH = 4'd7
  } pdu_kind_e;

endpackage

// File: rtl/egr_tcam_store.sv
module egr_tcam_store #(
  parameter int KEY_W     = egr_tcam_pkg::TCAM_KEY_W,
  parameter int ACT_W     = egr_tcam_pkg::TCAM_ACT_W,
  parameter int NUM_RULES = egr_tcam_pkg::TCAM_RULES,
  parameter int NUM_DFLT  = egr_tcam_pkg::TCAM_DEFAULTS,
  localparam int IDX_W    = $clog2(NUM_RULES),
  localparam int DFLT_W   = $clog2(NUM_DFLT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rule_we,
  input  logic                 dflt_we,
  input  logic [IDX_W-1:0]     addr,
  input  logic                 wvalid,
  input  logic [KEY_W-1:0]     wvalue,
  input  logic [KEY_W-1:0]     wmask,
  input  logic [ACT_W-1:0]     waction,
  input  logic [KEY_W-1:0]     key,
  output logic [NUM_RULES-1:0] match,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [ACT_W-1:0]     rd_action,
  input  logic [DFLT_W-1:0]    dflt_sel,
  output logic [ACT_W-1:0]     dflt_action
);

  // ternary compare of one rule: every cared-for bit must agree
  function automatic logic rule_agrees(input logic [KEY_W-1:0] k,
                                       input logic [KEY_W-1:0] v,
                                       input logic [KEY_W-1:0] m);
    return ((k ^ v) & m) == '0;
  endfunction

  logic [NUM_RULES-1:0] vld_q;
  logic [KEY_W-1:0]     val_q  [NUM_RULES];
  logic [KEY_W-1:0]     msk_q  [NUM_RULES];
  logic [ACT_W-1:0]     act_q  [NUM_RULES];
  logic [ACT_W-1:0]     dflt_q [NUM_DFLT];
  logic [DFLT_W-1:0]    dflt_waddr;

  assign dflt_waddr = addr[DFLT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (rule_we) begin
      vld_q[addr] <= wvalid;
    end
  end

  always_ff @(posedge clk) begin
    if (rule_we) begin
      val_q[addr] <= wvalue;
      msk_q[addr] <= wmask;
      act_q[addr] <= waction;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < NUM_DFLT; d++) dflt_q[d] <= '0;
    end else if (dflt_we) begin
      dflt_q[dflt_waddr] <= waction;
    end
  end

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_cmp
    assign match[g] = vld_q[g] && rule_agrees(key, val_q[g], msk_q[g]);
  end

  assign rd_action   = act_q[rd_idx];
  assign dflt_action = dflt_q[dflt_sel];

  // R5: a rule write lands with the written valid flag
  a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    rule_we |=> vld_q[$past(addr)] == $past(wvalid));

  // R9: a fallback write lands in the addressed slot
  a_r9_dflt_lands: assert property (@(posedge clk) disable iff (!rst_n)
    dflt_we |=> dflt_q[$past(dflt_waddr)] == $past(waction));

endmodule

// File: rtl/egr_tcam_prio.sv
module egr_tcam_prio #(
  parameter int NUM_RULES = egr_tcam_pkg::TCAM_RULES,
  localparam int IDX_W    = $clog2(NUM_RULES)
) (
  input  logic [NUM_RULES-1:0] match,
  output logic                 hit,
  output logic [IDX_W-1:0]     idx
);

  // lowest set bit wins; result {found, index}
  function automatic logic [IDX_W:0] lowest_set(input logic [NUM_RULES-1:0] m);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (m[i]) r = {1'b1, IDX_W'(i)};
    end
    return r;
  endfunction

  logic [IDX_W:0] enc;

  assign enc = lowest_set(match);
  assign hit = enc[IDX_W];
  assign idx = enc[IDX_W-1:0];

endmodule

// File: rtl/egr_tcam_sticky.sv
module egr_tcam_sticky #(
  parameter int NUM_RULES = egr_tcam_pkg::TCAM_RULES,
  localparam int IDX_W    = $clog2(NUM_RULES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_data
);

  logic [NUM_RULES-1:0] sticky_q;
  logic                 collide;

  assign collide = set_en && rd_en && (set_idx == rd_idx);

  // clear first, then set, so a win on the same edge survives the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
    end else begin
      if (rd_en)  sticky_q[rd_idx]  <= 1'b0;
      if (set_en) sticky_q[set_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= 1'b0;
    else if (rd_en) rd_data <= sticky_q[rd_idx];
  end

  // R6: a win leaves the bit set
  a_r6_win_sets: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> sticky_q[$past(set_idx)]);

  // R6: a read without a competing win clears the bit
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !collide) |=> !sticky_q[$past(rd_idx)]);

  // R7: a collision returns the earlier value and keeps the bit
  a_r7_collide_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> sticky_q[$past(rd_idx)] && (rd_data == $past(sticky_q[rd_idx])));

endmodule

// File: rtl/egr_tcam.sv
module egr_tcam #(
  parameter int KEY_W     = egr_tcam_pkg::TCAM_KEY_W,
  parameter int ACT_W     = egr_tcam_pkg::TCAM_ACT_W,
  parameter int NUM_RULES = egr_tcam_pkg::TCAM_RULES,
  parameter int NUM_DFLT  = egr_tcam_pkg::TCAM_DEFAULTS,
  localparam int IDX_W    = $clog2(NUM_RULES),
  localparam int DFLT_W   = $clog2(NUM_DFLT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_vld,
  input  logic [KEY_W-1:0] key,
  output logic             res_vld,
  output logic             res_hit,
  output logic [IDX_W-1:0] res_idx,
  output logic [ACT_W-1:0] res_act,
  input  logic             cfg_rule_we,
  input  logic             cfg_dflt_we,
  input  logic             cfg_rd_sticky,
  input  logic [IDX_W-1:0] cfg_addr,
  input  logic             cfg_valid,
  input  logic [KEY_W-1:0] cfg_value,
  input  logic [KEY_W-1:0] cfg_mask,
  input  logic [ACT_W-1:0] cfg_action,
  output logic             cfg_sticky
);

  import egr_tcam_pkg::*;

  logic [NUM_RULES-1:0] cmp_match;
  logic [NUM_RULES-1:0] s1_match;
  logic [NUM_RULES-1:0] s1_below;
  logic                 s1_vld;
  logic [DFLT_W-1:0]    s1_port;
  logic                 s1_hit;
  logic [IDX_W-1:0]     s1_idx;
  logic [ACT_W-1:0]     win_action;
  logic [ACT_W-1:0]     fb_action;
  logic                 win_event;

  egr_tcam_store #(
    .KEY_W(KEY_W), .ACT_W(ACT_W), .NUM_RULES(NUM_RULES), .NUM_DFLT(NUM_DFLT)
  ) i_store (
    .clk(clk), .rst_n(rst_n),
    .rule_we(cfg_rule_we), .dflt_we(cfg_dflt_we), .addr(cfg_addr),
    .wvalid(cfg_valid), .wvalue(cfg_value), .wmask(cfg_mask), .waction(cfg_action),
    .key(key), .match(cmp_match),
    .rd_idx(s1_idx), .rd_action(win_action),
    .dflt_sel(s1_port), .dflt_action(fb_action)
  );

  // stage 1: capture the match vector and the fallback choice
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_match <= '0;
      s1_port  <= '0;
    end else begin
      s1_vld <= key_vld;
      if (key_vld) begin
        s1_match <= cmp_match;
        s1_port  <= key[KEY_EPORT_LSB +: DFLT_W];
      end
    end
  end

  egr_tcam_prio #(.NUM_RULES(NUM_RULES)) i_prio (
    .match(s1_match), .hit(s1_hit), .idx(s1_idx)
  );

  assign win_event = s1_vld && s1_hit;
  assign s1_below  = (NUM_RULES'(1) << s1_idx) - NUM_RULES'(1);

  // stage 2: pick the action and present the result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld <= 1'b0;
      res_hit <= 1'b0;
      res_idx <= '0;
      res_act <= '0;
    end else begin
      res_vld <= s1_vld;
      if (s1_vld) begin
        res_hit <= s1_hit;
        res_idx <= s1_hit ? s1_idx : '0;
        res_act <= s1_hit ? win_action : fb_action;
      end
    end
  end

  egr_tcam_sticky #(.NUM_RULES(NUM_RULES)) i_sticky (
    .clk(clk), .rst_n(rst_n),
    .set_en(win_event), .set_idx(s1_idx),
    .rd_en(cfg_rd_sticky), .rd_idx(cfg_addr), .rd_data(cfg_sticky)
  );

  // R2: the winner matched and no lower rule did
  a_r2_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    win_event |-> s1_match[s1_idx] && ((s1_match & s1_below) == '0));

  // R3: a miss reports index 0
  a_r3_miss_index: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !res_hit) |-> res_idx == '0);

  // R4: result two cycles after the key
  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    key_vld |=> ##1 res_vld);

  // R4: no result without a key
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !key_vld |=> ##1 !res_vld);

endmodule

// File: tb/test_egr_tcam.sv
`timescale 1ns/1ps
module test_egr_tcam;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_vld = 1'b0;
  logic [49:0] key = '0;
  logic        res_vld, res_hit, cfg_sticky;
  logic [7:0]  res_idx;
  logic [64:0] res_act;
  logic        cfg_rule_we = 1'b0, cfg_dflt_we = 1'b0, cfg_rd_sticky = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic        cfg_valid = 1'b0;
  logic [49:0] cfg_value = '0, cfg_mask = '0;
  logic [64:0] cfg_action = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  egr_tcam i_egr_tcam (
    .clk(clk), .rst_n(rst_n), .key_vld(key_vld), .key(key),
    .res_vld(res_vld), .res_hit(res_hit), .res_idx(res_idx), .res_act(res_act),
    .cfg_rule_we(cfg_rule_we), .cfg_dflt_we(cfg_dflt_we), .cfg_rd_sticky(cfg_rd_sticky),
    .cfg_addr(cfg_addr), .cfg_valid(cfg_valid), .cfg_value(cfg_value),
    .cfg_mask(cfg_mask), .cfg_action(cfg_action), .cfg_sticky(cfg_sticky)
  );

  function automatic logic [64:0] fb_exp(input int p);
    return {1'b1, 32'(p * 7 + 1), 32'hC0DE_0000 | 32'(p)};
  endfunction

  function automatic logic [64:0] rule_act(input int r);
    return {1'b0, 32'hA5A5_0000 | 32'(r), 32'(r * 3 + 11)};
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_rule(input int r, input bit v, input logic [49:0] val,
                            input logic [49:0] msk);
    @(negedge clk);
    cfg_addr = 8'(r); cfg_valid = v; cfg_value = val; cfg_mask = msk;
    cfg_action = rule_act(r); cfg_rule_we = 1'b1;
    @(negedge clk);
    cfg_rule_we = 1'b0;
  endtask

  task automatic write_dflt(input int p);
    @(negedge clk);
    cfg_addr = 8'(p); cfg_action = fb_exp(p); cfg_dflt_we = 1'b1;
    @(negedge clk);
    cfg_dflt_we = 1'b0;
  endtask

  task automatic lookup(input logic [49:0] k);
    @(negedge clk);
    key = k; key_vld = 1'b1;
    @(negedge clk);
    key_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_sticky(input int r, output logic v);
    @(negedge clk);
    cfg_addr = 8'(r); cfg_rd_sticky = 1'b1;
    @(negedge clk);
    cfg_rd_sticky = 1'b0;
    v = cfg_sticky;
  endtask

  task automatic expect_hit(input string tag, input int r);
    check({tag, " vld"}, 128'(res_vld), 128'(1));
    check({tag, " hit"}, 128'(res_hit), 128'(1));
    check({tag, " idx"}, 128'(res_idx), 128'(r));
    check({tag, " act"}, 128'(res_act), 128'(rule_act(r)));
  endtask

  task automatic expect_miss(input string tag, input logic [49:0] k);
    check({tag, " vld"}, 128'(res_vld), 128'(1));
    check({tag, " hit"}, 128'(res_hit), 128'(0));
    check({tag, " idx"}, 128'(res_idx), 128'(0));
    check({tag, " act"}, 128'(res_act), 128'(fb_exp(int'(k[3:0]) % 8)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic        sv;
    logic [49:0] base, k1, k0, k3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    check("R8 res_vld after reset", 128'(res_vld), 128'(0));
    check("R8 res_hit after reset", 128'(res_hit), 128'(0));
    read_sticky(0, sv);
    check("R8 sticky 0 after reset", 128'(sv), 128'(0));
    read_sticky(255, sv);
    check("R8 sticky 255 after reset", 128'(sv), 128'(0));
    lookup(50'h3_0000_0000_0005);
    check("R8 empty table hit", 128'(res_hit), 128'(0));
    check("R8 fallback zero", 128'(res_act), 128'(0));

    // R9 / R3: fallback per egress port modulo 8
    for (int p = 0; p < 8; p++) write_dflt(p);
    for (int p = 0; p < 16; p++) begin
      k0 = 50'h1_2345_6789_AB00 | 50'(p);
      lookup(k0);
      expect_miss("R3 R9 port sweep", k0);
    end

    // R4: back-to-back lookups, results in order two cycles later
    @(negedge clk); key = 50'h1; key_vld = 1'b1;
    @(negedge clk); check("R4 no early result", 128'(res_vld), 128'(0));
    key = 50'h2;
    @(negedge clk); key = 50'h3;
    check("R4 first vld", 128'(res_vld), 128'(1));
    check("R4 first act", 128'(res_act), 128'(fb_exp(1)));
    @(negedge clk); key_vld = 1'b0;
    check("R4 second act", 128'(res_act), 128'(fb_exp(2)));
    @(negedge clk);
    check("R4 third vld", 128'(res_vld), 128'(1));
    check("R4 third act", 128'(res_act), 128'(fb_exp(3)));
    @(negedge clk);
    check("R4 drop after last", 128'(res_vld), 128'(0));

    // R1: single-bit masks across every key bit; other bits ignored
    base = 50'h2_AAAA_5555_3C3C;
    for (int b = 0; b < 50; b++) begin
      write_rule(10, 1'b1, ~base | (50'(1) << b), 50'(1) << b);
      k1 = base | (50'(1) << b);
      k0 = base & ~(50'(1) << b);
      lookup(k1);
      expect_hit("R1 care bit set", 10);
      lookup(k0);
      expect_miss("R1 care bit clear", k0);
    end

    // R5: invalidated rule and invalid wildcard never match
    write_rule(10, 1'b0, '0, '0);
    write_rule(1, 1'b0, '0, '0);
    lookup(base);
    expect_miss("R5 invalid rules", base);

    // R2: lowest matching index wins
    write_rule(200, 1'b1, '0, '0);
    write_rule(5, 1'b1, '0, '0);
    lookup(base);
    expect_hit("R2 two wildcards", 5);
    k3 = 50'h0_F00D_1234_5678;
    write_rule(3, 1'b1, k3, '1);
    lookup(k3);
    expect_hit("R2 exact beats wildcard", 3);
    lookup(k3 ^ 50'h1);
    expect_hit("R2 exact misses", 5);

    // R6: sticky read and clear
    read_sticky(5, sv);
    check("R6 sticky 5 set", 128'(sv), 128'(1));
    read_sticky(5, sv);
    check("R6 sticky 5 cleared", 128'(sv), 128'(0));
    read_sticky(1, sv);
    check("R6 sticky invalid rule", 128'(sv), 128'(0));
    read_sticky(3, sv);
    check("R6 sticky 3 set", 128'(sv), 128'(1));
    read_sticky(200, sv);
    check("R6 sticky 200 never won", 128'(sv), 128'(0));

    // R5: rule removal takes effect on the next lookup
    write_rule(5, 1'b0, '0, '0);
    lookup(base);
    expect_hit("R5 after removal", 200);

    // R7: sticky read on the same edge as a win
    read_sticky(200, sv);
    check("R7 preclear", 128'(sv), 128'(1));
    @(negedge clk); key = base; key_vld = 1'b1;
    @(negedge clk); key_vld = 1'b0; cfg_addr = 8'd200; cfg_rd_sticky = 1'b1;
    @(negedge clk); cfg_rd_sticky = 1'b0;
    check("R7 read returns old", 128'(cfg_sticky), 128'(0));
    expect_hit("R7 lookup result", 200);
    read_sticky(200, sv);
    check("R7 bit kept", 128'(sv), 128'(1));
    read_sticky(200, sv);
    check("R7 then cleared", 128'(sv), 128'(0));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule